// File: doc/BRIEF.md
# Transmit Request / Terminal-Ready Pin Controller

This block owns one active-low output pin that serves one of two purposes. In terminal-ready mode the pin reports a modem ready bit. In request mode the pin asks a DMA engine or CPU for more transmit bytes. The block holds a small transmit queue. Writes enter the queue through a multi-cycle active-low write strobe, and the serializer takes bytes out with a single-cycle pop strobe. A configuration register selects the pin's purpose, the queue level that raises a request, and whether a write drops the request at the start of the strobe or at its end.

In request mode the pin reflects the queue state alone. The transmitter being idle or disabled does not change it. After every completed write the pin returns high for at least one cycle, so the requester always sees separate transfers. A hardware reset or a channel reset clears the configuration, empties the queue and drives the pin high.

Top module: `txreq_pin_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `pin_n` is 1 and `tx_overrun` is 0, and the queue is empty.
- R2: With the function bit at 0 (terminal-ready mode), `pin_n` equals the inverse of the ready bit. The new level is visible in the cycle after the configuration write.
- R3: With the function bit at 1 (request mode), the ready bit has no effect. An empty queue with no write in progress drives `pin_n` low.
- R4: With the threshold bit at 1 (whole queue empty), the request rises only after occupancy has reached zero. That is one cycle after the pop that removed the last byte.
- R5: With the threshold bit at 0 (exit slot empty), the request rises in the same cycle as the pop that removes the last byte. `pin_n` is low right after that clock edge.
- R6: With the timing bit at 0, `pin_n` stays low for the whole time `wr_n` is low. It goes high after the edge at which `wr_n` is sampled high again.
- R7: With the timing bit at 1, `pin_n` goes high after the first edge at which `wr_n` is sampled low.
- R8: After every completed write, `pin_n` is high for at least one cycle in request mode. This holds even when a pop happens in the same cycle as the write's end.
- R9: A byte is captured on the cycle `wr_n` rises and is delivered in first-in first-out order. `tx_data` shows the oldest byte. A pop on an empty queue is ignored.
- R10: A write that ends while the queue holds `DEPTH` bytes is dropped, even if a pop happens in the same cycle. It sets `tx_overrun`, which stays 1 until a reset.
- R11: `chan_rst` has the same effect as `rst`. It clears the configuration to terminal-ready mode with the ready bit off, empties the queue and clears `tx_overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| chan_rst | input | 1 | Synchronous active-high channel reset |
| cfg_we | input | 1 | Loads the four configuration bits below |
| cfg_req_mode | input | 1 | Pin function: 1 request, 0 terminal-ready |
| cfg_whole_empty | input | 1 | Threshold: 1 whole queue empty, 0 exit slot empty |
| cfg_early_clr | input | 1 | Timing: 1 drop at strobe start, 0 at strobe end |
| cfg_dtr | input | 1 | Terminal-ready bit (active high) |
| wr_n | input | 1 | Active-low multi-cycle write strobe |
| wr_data | input | WIDTH | Byte written at the rising end of `wr_n` |
| pop | input | 1 | Serializer takes the oldest byte |
| tx_data | output | WIDTH | Oldest queued byte |
| tx_overrun | output | 1 | Sticky flag for a write dropped on a full queue |
| pin_n | output | 1 | Shared active-low pin |

## Verification
The end of a write strobe, which pushes a byte and blanks the request, can fall in the same cycle as a serializer pop. This case is provoked by writing to a queue that already holds one byte, with exit-slot threshold selected, and raising `wr_n` on the same edge that `pop` is high. Occupancy then stays at one. In that state the threshold rule alone would raise the request, so the bench judges the case by requiring `pin_n` to stay high after that edge and `tx_data` to show the new byte. A second pop must then bring the pin low.

// File: rtl/txreq_pkg.sv
package txreq_pkg;

    parameter int unsigned TXQ_DEPTH = 4;
    parameter int unsigned TXQ_WIDTH = 8;

    typedef enum logic {
        PIN_AS_DTR = 1'b0,
        PIN_AS_REQ = 1'b1
    } pin_fn_e;

    typedef struct packed {
        pin_fn_e fn;
        logic    whole_empty;
        logic    early_clr;
        logic    dtr_on;
    } pin_cfg_t;

    localparam pin_cfg_t CFG_RESET = '{fn: PIN_AS_DTR, whole_empty: 1'b0,
                                       early_clr: 1'b0, dtr_on: 1'b0};

    // Request threshold: whole-queue mode needs zero occupancy; exit-slot
    // mode also counts the last byte leaving in this cycle.
    function automatic logic slot_free(input logic whole, input logic lvl_zero,
                                       input logic lvl_one, input logic popping);
        return lvl_zero || (!whole && lvl_one && popping);
    endfunction

endpackage

// File: rtl/txreq_strobe.sv
module txreq_strobe (
    input  logic clk,
    input  logic rst,
    input  logic wr_n,
    output logic wr_active,
    output logic wr_finish
);
    logic wr_q;

    always_ff @(posedge clk) begin
        if (rst) wr_q <= 1'b1;
        else     wr_q <= wr_n;
    end

    assign wr_active = ~wr_n;
    assign wr_finish = ~wr_q & wr_n;
endmodule

// File: rtl/txreq_fifo.sv
module txreq_fifo #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned WIDTH = 8,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [LVL_W-1:0] level,
    output logic             pop_ok,
    output logic             overrun
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
    logic             full, empty, push_ok;

    assign full    = (level == LVL_W'(DEPTH));
    assign empty   = (level == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;

    generate
        if (DEPTH > 1 && (DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
            assign wr_nxt = wr_ptr + 1'b1;
            assign rd_nxt = rd_ptr + 1'b1;
        end else begin : g_wrap
            assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            level   <= '0;
            overrun <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= wr_nxt;
            if (pop_ok)  rd_ptr <= rd_nxt;
            level   <= level + LVL_W'(push_ok) - LVL_W'(pop_ok);
            overrun <= overrun | (push & full);
        end
    end

    assign dout = mem[rd_ptr];
endmodule

// File: rtl/txreq_req_gen.sv
module txreq_req_gen
    import txreq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  pin_cfg_t cfg,
    input  logic     lvl_zero,
    input  logic     lvl_one,
    input  logic     pop_ok,
    input  logic     wr_active,
    input  logic     wr_finish,
    output logic     req_q
);
    logic blank;

    // End of every write forces one inactive cycle; early mode also blanks
    // for the whole strobe.
    assign blank = wr_finish | (cfg.early_clr & wr_active);

    always_ff @(posedge clk) begin
        if (rst || clr) req_q <= 1'b0;
        else            req_q <= slot_free(cfg.whole_empty, lvl_zero, lvl_one, pop_ok) & ~blank;
    end
endmodule

// File: rtl/txreq_pin_ctrl.sv
module txreq_pin_ctrl
    import txreq_pkg::*;
#(
    parameter int unsigned DEPTH = TXQ_DEPTH,
    parameter int unsigned WIDTH = TXQ_WIDTH,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chan_rst,
    input  logic             cfg_we,
    input  logic             cfg_req_mode,
    input  logic             cfg_whole_empty,
    input  logic             cfg_early_clr,
    input  logic             cfg_dtr,
    input  logic             wr_n,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             pop,
    output logic [WIDTH-1:0] tx_data,
    output logic             tx_overrun,
    output logic             pin_n
);
    pin_cfg_t         cfg_q;
    logic [LVL_W-1:0] level;
    logic             pop_ok, wr_active, wr_finish, req_q;
    logic             mode_q, early_q;

    always_ff @(posedge clk) begin
        if (rst || chan_rst) cfg_q <= CFG_RESET;
        else if (cfg_we)     cfg_q <= '{fn: pin_fn_e'(cfg_req_mode), whole_empty: cfg_whole_empty,
                                        early_clr: cfg_early_clr, dtr_on: cfg_dtr};
    end

    txreq_strobe u_strobe (
        .clk       (clk),
        .rst       (rst),
        .wr_n      (wr_n),
        .wr_active (wr_active),
        .wr_finish (wr_finish)
    );

    txreq_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .clr     (chan_rst),
        .push    (wr_finish),
        .din     (wr_data),
        .pop     (pop),
        .dout    (tx_data),
        .level   (level),
        .pop_ok  (pop_ok),
        .overrun (tx_overrun)
    );

    txreq_req_gen u_req (
        .clk       (clk),
        .rst       (rst),
        .clr       (chan_rst),
        .cfg       (cfg_q),
        .lvl_zero  (level == '0),
        .lvl_one   (level == LVL_W'(1)),
        .pop_ok    (pop_ok),
        .wr_active (wr_active),
        .wr_finish (wr_finish),
        .req_q     (req_q)
    );

    assign mode_q  = (cfg_q.fn == PIN_AS_REQ);
    assign early_q = cfg_q.early_clr;
    assign pin_n   = mode_q ? ~req_q : ~cfg_q.dtr_on;
endmodule

// File: rtl/txreq_pin_ctrl_chk.sv
module txreq_pin_ctrl_chk #(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             chan_rst,
    input logic             cfg_we,
    input logic             cfg_req_mode,
    input logic             cfg_dtr,
    input logic             wr_n,
    input logic             pin_n,
    input logic             tx_overrun,
    input logic             mode_q,
    input logic             early_q,
    input logic [LVL_W-1:0] level
);
    a_r1_reset_idle: assert property (@(posedge clk)
        (rst || chan_rst) |=> (pin_n && !tx_overrun));

    a_r2_dtr_level: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !cfg_req_mode && !chan_rst) |=> (pin_n == !$past(cfg_dtr)));

    a_r6_hold_during_write: assert property (@(posedge clk) disable iff (rst)
        (mode_q && !early_q && !pin_n && !wr_n && !cfg_we && !chan_rst && level == '0)
        |=> !pin_n);

    a_r7_early_drop: assert property (@(posedge clk) disable iff (rst)
        (mode_q && early_q && !wr_n && !cfg_we) |=> pin_n);

    a_r8_gap_after_write: assert property (@(posedge clk) disable iff (rst)
        (mode_q && !cfg_we && $rose(wr_n)) |=> pin_n);

    a_r10_overrun_set: assert property (@(posedge clk) disable iff (rst || chan_rst)
        (level == LVL_W'(DEPTH) && $rose(wr_n)) |=> tx_overrun);

    a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (rst || chan_rst)
        tx_overrun |=> tx_overrun);
endmodule

bind txreq_pin_ctrl txreq_pin_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .chan_rst     (chan_rst),
    .cfg_we       (cfg_we),
    .cfg_req_mode (cfg_req_mode),
    .cfg_dtr      (cfg_dtr),
    .wr_n         (wr_n),
    .pin_n        (pin_n),
    .tx_overrun   (tx_overrun),
    .mode_q       (mode_q),
    .early_q      (early_q),
    .level        (level)
);

// File: tb/txreq_pin_ctrl_test.sv
module txreq_pin_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1, chan_rst = 1'b0, cfg_we = 1'b0;
    logic       cfg_req_mode = 1'b0, cfg_whole_empty = 1'b0, cfg_early_clr = 1'b0, cfg_dtr = 1'b0;
    logic       wr_n = 1'b1, pop = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] tx_data;
    logic       tx_overrun, pin_n;
    int         n_chk = 0, n_fail = 0, cycles = 0;

    always #5 clk = ~clk;

    txreq_pin_ctrl uut (.*);

    // {req_mode, whole_empty, early_clr, dtr, expected pin_n}, empty queue
    localparam logic [4:0] CFG_VEC [6] = '{
        5'b0_0_0_0_1, 5'b0_0_0_1_0, 5'b1_1_0_0_0,
        5'b1_0_0_1_0, 5'b0_1_1_1_0, 5'b1_0_1_0_0
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_cfg(input logic m, input logic w, input logic e, input logic d);
        cfg_we = 1'b1; cfg_req_mode = m; cfg_whole_empty = w; cfg_early_clr = e; cfg_dtr = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic quick_write(input logic [7:0] d);
        wr_data = d; wr_n = 1'b0;
        step();
        wr_n = 1'b1;
        step();
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        step(); step(); step();
        chk("R1 pin after reset", pin_n, 1);
        chk("R1 overrun after reset", tx_overrun, 0);
        rst = 1'b0;
        step();
        chk("R1 pin idle", pin_n, 1);

        // Configuration table on an empty queue (R2 terminal-ready, R3 request)
        for (int i = 0; i < 6; i++) begin
            load_cfg(CFG_VEC[i][4], CFG_VEC[i][3], CFG_VEC[i][2], CFG_VEC[i][1]);
            step();
            chk(CFG_VEC[i][4] ? "R3 request mode pin" : "R2 ready mode pin", pin_n, CFG_VEC[i][0]);
        end

        // R6 late drop, R4 whole-empty threshold
        load_cfg(1'b1, 1'b1, 1'b0, 1'b0);
        step();
        wr_data = 8'hA1; wr_n = 1'b0;
        step(); chk("R6 held during strobe", pin_n, 0);
        step(); chk("R6 held during strobe 2", pin_n, 0);
        wr_n = 1'b1;
        step(); chk("R6 high after strobe end", pin_n, 1);
        chk("R9 captured byte", tx_data, 8'hA1);
        step(); chk("R4 high while byte queued", pin_n, 1);
        pop = 1'b1; step(); pop = 1'b0;
        chk("R4 not yet on emptying pop", pin_n, 1);
        step(); chk("R4 low once empty", pin_n, 0);

        // R5 exit-slot threshold
        load_cfg(1'b1, 1'b0, 1'b0, 1'b0);
        quick_write(8'hB2);
        chk("R8 gap after write", pin_n, 1);
        pop = 1'b1; step(); pop = 1'b0;
        chk("R5 low on emptying pop", pin_n, 0);

        // R7 early drop
        load_cfg(1'b1, 1'b1, 1'b1, 1'b0);
        step(); chk("R3 request idle", pin_n, 0);
        wr_data = 8'hC3; wr_n = 1'b0;
        step(); chk("R7 high at strobe start", pin_n, 1);
        wr_n = 1'b1;
        step(); chk("R7 high after strobe end", pin_n, 1);
        pop = 1'b1; step(); pop = 1'b0;
        step(); chk("R4 low after drain", pin_n, 0);

        // R8 write end coinciding with a pop, exit-slot threshold
        load_cfg(1'b1, 1'b0, 1'b0, 1'b0);
        quick_write(8'hD4);
        wr_data = 8'hE5; wr_n = 1'b0;
        step(); chk("R6 queued byte keeps pin high", pin_n, 1);
        wr_n = 1'b1; pop = 1'b1;
        step(); pop = 1'b0;
        chk("R8 high on push with pop", pin_n, 1);
        chk("R9 head after push with pop", tx_data, 8'hE5);
        step(); chk("R8 still one byte", pin_n, 1);
        pop = 1'b1; step(); pop = 1'b0;
        chk("R5 low after last pop", pin_n, 0);

        // R9 order, R10 overrun
        load_cfg(1'b0, 1'b0, 1'b0, 1'b0);
        quick_write(8'h11); quick_write(8'h22); quick_write(8'h33); quick_write(8'h44);
        chk("R9 oldest first", tx_data, 8'h11);
        chk("R10 no overrun when filling", tx_overrun, 0);
        quick_write(8'h55);
        chk("R10 overrun on full", tx_overrun, 1);
        pop = 1'b1; step(); chk("R9 second", tx_data, 8'h22);
        step(); chk("R9 third", tx_data, 8'h33);
        step(); chk("R10 dropped byte absent", tx_data, 8'h44);
        step(); step(); pop = 1'b0;
        quick_write(8'h66);
        chk("R9 pop on empty ignored", tx_data, 8'h66);
        chk("R10 overrun sticky", tx_overrun, 1);
        load_cfg(1'b1, 1'b1, 1'b0, 1'b0);
        step(); chk("R9 one byte left after empty pops", pin_n, 1);

        // R11 channel reset
        load_cfg(1'b0, 1'b0, 1'b0, 1'b1);
        chk("R2 ready on", pin_n, 0);
        chan_rst = 1'b1; step(); chan_rst = 1'b0;
        chk("R11 pin high", pin_n, 1);
        chk("R11 overrun cleared", tx_overrun, 0);
        load_cfg(1'b1, 1'b1, 1'b0, 1'b0);
        step(); chk("R11 queue flushed", pin_n, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule